// File: doc/BRIEF.md
# Video Memory Block-Write Unit

This block is a synchronous model of a small video memory whose words are four bits wide. One request per clock selects a cycle type through two special-function flags, one sampled at the row-strobe point and one at the column-strobe point. The cycle types are a plain write, a load of a four-bit colour register, a load of a four-bit persistent bit-plane mask register, and a block write. A block write copies the colour value into up to four neighbouring columns in one clock.

In a block write, the two low column address bits are ignored. The data bus becomes a four-bit column-select mask that picks which of the four columns in the aligned group receive the colour. On top of that, a per-bit plane mask can protect individual data bits. The plane mask comes from one of two places: the data present at the row-strobe point, used for that cycle only, or the persistent mask register. A separate read port returns a stored word one clock after its address is presented. This port lets a frame-buffer controller or a bench observe the array.

Top module: `vram_block_writer`

## Requirements
- R1: After reset the read data output is 0, the colour register is 0 and the persistent mask register is 0. A block write with all column-select bits set and plane masking off therefore writes 0 to all four columns. A block write that uses the persistent mask before any mask load changes nothing.
- R2: A request with reqValid=1, wrEn=1, sfRow=0 and sfCol=0 is a plain write. It stores dataIn at {rowAddr, colAddr}, subject to the plane mask of R7/R8.
- R3: A request with reqValid=1, wrEn=1, sfRow=1 and sfCol=1 loads dataIn into the colour register and leaves the array unchanged.
- R4: The colour register keeps its value across plain writes, mask loads, block writes and idle cycles until the next colour load.
- R5: A request with reqValid=1, wrEn=1, sfRow=0 and sfCol=1 is a block write to the aligned group whose column base is colAddr with bits 1:0 cleared. The value of colAddr[1:0] has no effect.
- R6: In a block write, dataIn bit k enables the column at group offset k (k = 0..3). A 1 writes the colour to that column. A 0 leaves that column unchanged.
- R7: With wpbEn=0 all four bits are written. With wpbEn=1 and wpbPersist=0, rasData is the plane mask for that cycle only: bit i=1 lets data bit i change, and 0 keeps it.
- R8: A request with reqValid=1, wrEn=1, sfRow=1 and sfCol=0 loads dataIn into the persistent mask register and leaves the array unchanged. With wpbEn=1 and wpbPersist=1, that register is the plane mask for plain and block writes.
- R9: In a block write, bit i of column k changes only when column-select bit k and plane-mask bit i are both 1. All other bits keep their contents.
- R10: A request with reqValid=0 or wrEn=0 changes neither the array nor either register.
- R11: rdData presents the word at {rdRow, rdCol} one clock after the address is applied, and reflects writes completed in earlier clocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | A memory cycle is requested this clock |
| wrEn | input | 1 | Write strobe; data is captured only when this and reqValid are both high |
| sfRow | input | 1 | Special-function flag at the row-strobe point |
| sfCol | input | 1 | Special-function flag at the column-strobe point |
| wpbEn | input | 1 | Enables per-bit plane masking for this cycle |
| wpbPersist | input | 1 | Selects the persistent mask register instead of rasData |
| rowAddr | input | ROW_W | Row address |
| colAddr | input | COL_W | Column address; bits 1:0 unused in block writes |
| rasData | input | 4 | Data bus value at the row-strobe point (per-cycle plane mask) |
| dataIn | input | 4 | Write data, colour value, mask value or column-select mask |
| rdRow | input | ROW_W | Read row address |
| rdCol | input | COL_W | Read column address |
| rdData | output | 4 | Registered read data |

## Verification
The bench writes a block write with colAddr[1:0] set to 3 and checks that the aligned group is hit rather than a shifted one. A design that kept the low address bits would write past the group or into the wrong columns. Sparse column-select patterns such as 0101 and 1000 verify the mapping from select bit to column. A reversed or rotated mapping would write the colour into neighbours that should stay intact. Each plane-mask source is combined with a partial column select, and the following unmasked cycle checks that the per-cycle mask does not leak into it. The bench also confirms that colour and mask loads, as well as requests without the write strobe, leave the array and the colour register untouched. A decoder that mixed up the flag combinations would corrupt stored words or lose the colour.

// File: rtl/vbw_pkg.sv
package vbw_pkg;

  localparam int DW    = 4;          // bits per stored word
  localparam int GRP   = 4;          // columns touched by one block write
  localparam int GRP_W = $clog2(GRP);

  typedef enum logic [2:0] {
    CYC_IDLE,
    CYC_WRITE,
    CYC_COLOR,
    CYC_MASK,
    CYC_BLOCK
  } cyc_e;

  // strobes from control to the array
  typedef struct packed {
    logic          wr;       // plain single-column write
    logic          blk;      // block write to an aligned group
    logic [DW-1:0] bitMask;  // plane mask, 1 = bit may change
    logic [GRP-1:0] colMask; // group column select
    logic [DW-1:0] value;    // data or colour to store
  } strobe_t;

endpackage

// File: rtl/vbw_ctrl.sv
module vbw_ctrl
  import vbw_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reqValid,
  input  logic          wrEn,
  input  logic          sfRow,
  input  logic          sfCol,
  input  logic          wpbEn,
  input  logic          wpbPersist,
  input  logic [DW-1:0] rasData,
  input  logic [DW-1:0] dataIn,
  output strobe_t       stb
);

  cyc_e          cycKind;
  logic [DW-1:0] colorReg;
  logic [DW-1:0] maskReg;
  logic [DW-1:0] planeMask;

  // cycle decode: capture only when request and write strobe coincide
  always_comb begin
    cycKind = CYC_IDLE;
    if (reqValid && wrEn) begin
      unique case ({sfRow, sfCol})
        2'b11:   cycKind = CYC_COLOR;
        2'b10:   cycKind = CYC_MASK;
        2'b01:   cycKind = CYC_BLOCK;
        default: cycKind = CYC_WRITE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      colorReg <= '0;
      maskReg  <= '0;
    end else begin
      if (cycKind == CYC_COLOR) colorReg <= dataIn;
      if (cycKind == CYC_MASK)  maskReg  <= dataIn;
    end
  end

  // plane mask source selection
  always_comb begin
    if (!wpbEn)          planeMask = '1;
    else if (wpbPersist) planeMask = maskReg;
    else                 planeMask = rasData;
  end

  always_comb begin
    stb         = '0;
    stb.bitMask = planeMask;
    stb.value   = dataIn;
    case (cycKind)
      CYC_WRITE: stb.wr = 1'b1;
      CYC_BLOCK: begin
        stb.blk     = 1'b1;
        stb.colMask = dataIn[GRP-1:0];
        stb.value   = colorReg;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/vbw_array.sv
module vbw_array
  import vbw_pkg::*;
#(
  parameter int ROW_W = 2,
  parameter int COL_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  strobe_t          stb,
  input  logic [ROW_W-1:0] rowAddr,
  input  logic [COL_W-1:0] colAddr,
  input  logic [ROW_W-1:0] rdRow,
  input  logic [COL_W-1:0] rdCol,
  output logic [DW-1:0]    rdData
);

  localparam int IDX_W = ROW_W + COL_W;
  localparam int DEPTH = 1 << IDX_W;

  logic [DW-1:0]    mem [DEPTH];
  logic [IDX_W-1:0] wrIdx;
  logic [DW-1:0]    wrNext;
  logic [IDX_W-1:0] grpIdx  [GRP];
  logic [DW-1:0]    grpNext [GRP];

  assign wrIdx  = {rowAddr, colAddr};
  assign wrNext = (mem[wrIdx] & ~stb.bitMask) | (stb.value & stb.bitMask);

  // one merge lane per column of the aligned group
  for (genvar k = 0; k < GRP; k++) begin : g_lane
    assign grpIdx[k]  = {rowAddr, colAddr[COL_W-1:GRP_W], GRP_W'(k)};
    assign grpNext[k] = (mem[grpIdx[k]] & ~stb.bitMask) | (stb.value & stb.bitMask);
  end

  always_ff @(posedge clk) begin
    if (stb.wr) mem[wrIdx] <= wrNext;
    if (stb.blk) begin
      for (int k = 0; k < GRP; k++) begin
        if (stb.colMask[k]) mem[grpIdx[k]] <= grpNext[k];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) rdData <= '0;
    else        rdData <= mem[{rdRow, rdCol}];
  end

endmodule

// File: rtl/vram_block_writer.sv
module vram_block_writer
  import vbw_pkg::*;
#(
  parameter int ROW_W = 2,
  parameter int COL_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reqValid,
  input  logic             wrEn,
  input  logic             sfRow,
  input  logic             sfCol,
  input  logic             wpbEn,
  input  logic             wpbPersist,
  input  logic [ROW_W-1:0] rowAddr,
  input  logic [COL_W-1:0] colAddr,
  input  logic [3:0]       rasData,
  input  logic [3:0]       dataIn,
  input  logic [ROW_W-1:0] rdRow,
  input  logic [COL_W-1:0] rdCol,
  output logic [3:0]       rdData
);

  strobe_t stb;

  vbw_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .reqValid   (reqValid),
    .wrEn       (wrEn),
    .sfRow      (sfRow),
    .sfCol      (sfCol),
    .wpbEn      (wpbEn),
    .wpbPersist (wpbPersist),
    .rasData    (rasData),
    .dataIn     (dataIn),
    .stb        (stb)
  );

  vbw_array #(.ROW_W(ROW_W), .COL_W(COL_W)) u_array (
    .clk     (clk),
    .rst_n   (rst_n),
    .stb     (stb),
    .rowAddr (rowAddr),
    .colAddr (colAddr),
    .rdRow   (rdRow),
    .rdCol   (rdCol),
    .rdData  (rdData)
  );

endmodule

// File: rtl/vram_block_writer_chk.sv
module vram_block_writer_chk
  import vbw_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       reqValid,
  input logic       wrEn,
  input logic       sfRow,
  input logic       wpbEn,
  input logic [3:0] dataIn,
  input strobe_t    stb
);

  p_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(reqValid && wrEn) |-> (!stb.wr && !stb.blk));

  // colour loads (R3) and mask loads (R8) never touch the array
  p_noload_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (reqValid && wrEn && sfRow) |-> (!stb.wr && !stb.blk));

  p_colsel_r6: assert property (@(posedge clk) disable iff (!rst_n)
    stb.blk |-> (stb.colMask == dataIn));

  p_single_op_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(stb.wr && stb.blk));

  p_nomask_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((stb.wr || stb.blk) && !wpbEn) |-> (stb.bitMask == 4'hF));

  p_color_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (stb.blk && $past(stb.blk) && $past(rst_n) &&
     !$past(reqValid && wrEn && sfRow && !stb.blk)) |-> (stb.value == $past(stb.value)));

endmodule

bind vram_block_writer vram_block_writer_chk u_chk (.*);

// File: tb/test_vram_block_writer.sv
`timescale 1ns/1ps
module test_vram_block_writer;

  localparam int ROW_W = 2;
  localparam int COL_W = 9;
  localparam int NCOL  = 1 << COL_W;
  localparam int NROW  = 1 << ROW_W;

  logic             clk = 0;
  logic             rst_n = 0;
  logic             reqValid = 0, wrEn = 0, sfRow = 0, sfCol = 0;
  logic             wpbEn = 0, wpbPersist = 0;
  logic [ROW_W-1:0] rowAddr = '0, rdRow = '0;
  logic [COL_W-1:0] colAddr = '0, rdCol = '0;
  logic [3:0]       rasData = '0, dataIn = '0;
  logic [3:0]       rdData;

  always #10 clk = ~clk;   // 50 MHz

  vram_block_writer #(.ROW_W(ROW_W), .COL_W(COL_W)) i_vram_block_writer (.*);

  int vectors = 0;
  int errors  = 0;

  logic [3:0] model [NROW*NCOL];
  logic [3:0] colorM = 4'h0;
  logic [3:0] maskM  = 4'h0;

  logic [3:0] expQ [$];
  string      tagQ [$];
  logic       rdPending = 0;
  logic       done = 0;

  // drive one request cycle and update the reference
  task automatic cyc(input logic v, input logic we, input logic sr, input logic sc,
                     input logic wpb, input logic pers, input logic [3:0] ras,
                     input int row, input int col, input logic [3:0] d);
    logic [3:0] bm;
    int base;
    @(negedge clk);
    reqValid = v; wrEn = we; sfRow = sr; sfCol = sc;
    wpbEn = wpb; wpbPersist = pers; rasData = ras;
    rowAddr = ROW_W'(row); colAddr = COL_W'(col); dataIn = d;
    if (v && we) begin
      bm = !wpb ? 4'hF : (pers ? maskM : ras);
      if (sr && sc) colorM = d;
      else if (sr) maskM = d;
      else if (sc) begin
        base = row*NCOL + (col & ~3);
        for (int k = 0; k < 4; k++)
          if (d[k]) model[base+k] = (model[base+k] & ~bm) | (colorM & bm);
      end else
        model[row*NCOL+col] = (model[row*NCOL+col] & ~bm) | (d & bm);
    end
  endtask

  task automatic wr(input int row, input int col, input logic [3:0] d);
    cyc(1, 1, 0, 0, 0, 0, 4'h0, row, col, d);
  endtask

  task automatic rd(input int row, input int col, input string tag);
    @(negedge clk);
    reqValid = 0; wrEn = 0;
    rdRow = ROW_W'(row); rdCol = COL_W'(col);
    expQ.push_back(model[row*NCOL+col]);
    tagQ.push_back(tag);
    rdPending = 1;
  endtask

  task automatic rdGrp(input int row, input int base, input string tag);
    for (int k = 0; k < 4; k++) rd(row, base + k, tag);
  endtask

  // monitor: compare each read one clock after its address
  initial begin
    forever begin
      @(posedge clk);
      if (rdPending) begin
        logic [3:0] e;
        string t;
        rdPending = 0;
        #5;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        vectors++;
        if (rdData !== e) begin
          errors++;
          $display("FAIL %s: rdData=%h expected=%h", t, rdData, e);
        end
      end
    end
  end

  initial begin
    #(200000 * 20);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    vectors++;
    if (rdData !== 4'h0) begin
      errors++;
      $display("FAIL R1 reset read: actual=%h expected=0", rdData);
    end

    // fill the region used by the test
    for (int r = 0; r < NROW; r++)
      for (int c = 0; c < 64; c++) wr(r, c, 4'((r*7 + c*3 + 1) & 15));
    rd(0, 0, "R2 fill"); rd(3, 63, "R2 fill"); rd(2, 17, "R2 fill");

    // R1: persistent mask is zero after reset -> nothing changes
    cyc(1, 1, 0, 1, 1, 1, 4'h0, 0, 4, 4'hF);
    rdGrp(0, 4, "R1 zero persistent mask");
    // R1: colour zero, masking off -> four zeros
    cyc(1, 1, 0, 1, 0, 0, 4'h0, 0, 0, 4'hF);
    rdGrp(0, 0, "R1 reset colour");

    // R2: plain writes
    wr(1, 9, 4'h5); wr(1, 10, 4'hC);
    rd(1, 9, "R2 write"); rd(1, 10, "R2 write");

    // R3: colour load leaves the array alone
    cyc(1, 1, 1, 1, 0, 0, 4'h0, 1, 5, 4'hA);
    rd(1, 5, "R3 colour load no write");

    // R5/R6: low bits 11 ignored, sparse select 0101
    cyc(1, 1, 0, 1, 0, 0, 4'h0, 1, 16 + 3, 4'b0101);
    rdGrp(1, 16, "R5 R6 block 0101");
    cyc(1, 1, 0, 1, 0, 0, 4'h0, 2, 20 + 1, 4'b1000);
    rdGrp(2, 20, "R6 block 1000");
    rd(2, 24, "R5 neighbour group");

    // R10: no strobe, no change (array and colour)
    cyc(1, 0, 0, 0, 0, 0, 4'h0, 3, 30, 4'h9);
    cyc(0, 1, 0, 0, 0, 0, 4'h0, 3, 31, 4'h9);
    cyc(1, 0, 1, 1, 0, 0, 4'h0, 3, 30, 4'h3);
    rd(3, 30, "R10 no wrEn"); rd(3, 31, "R10 no reqValid");

    // R4: colour survives other cycle types
    wr(0, 40, 4'h1);
    cyc(1, 1, 1, 0, 0, 0, 4'h0, 0, 0, 4'h0);
    cyc(1, 1, 0, 1, 0, 0, 4'h0, 3, 32, 4'hF);
    rdGrp(3, 32, "R4 colour retained");

    // R7 / R9: per-cycle mask with partial select
    cyc(1, 1, 1, 1, 0, 0, 4'h0, 0, 0, 4'h5);
    cyc(1, 1, 0, 1, 1, 0, 4'b0011, 2, 36, 4'b0110);
    rdGrp(2, 36, "R7 R9 per-cycle mask");
    wr(2, 37, 4'hE);
    rd(2, 37, "R7 mask not persistent");
    cyc(1, 1, 0, 0, 1, 0, 4'b1001, 1, 41, 4'h6);
    rd(1, 41, "R7 masked plain write");

    // R8: persistent mask register
    cyc(1, 1, 1, 0, 0, 0, 4'h0, 1, 44, 4'b1100);
    rd(1, 44, "R8 mask load no write");
    cyc(1, 1, 1, 1, 0, 0, 4'h0, 0, 0, 4'hF);
    cyc(1, 1, 0, 1, 1, 1, 4'h3, 1, 48, 4'b1011);
    rdGrp(1, 48, "R8 R9 persistent block");
    cyc(1, 1, 0, 0, 1, 1, 4'hF, 3, 50, 4'h0);
    rd(3, 50, "R8 persistent plain write");

    // R11: back-to-back reads of different words
    wr(0, 60, 4'h7); wr(0, 61, 4'h8);
    rd(0, 60, "R11 latency"); rd(0, 61, "R11 latency"); rd(0, 60, "R11 latency");

    repeat (4) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

endmodule